// File: doc/BRIEF.md
# Receiver Power-Up Sequencer

This block takes a radio receiver from rest to active reception. While it sits in its rest state it watches a software receive-enable level. When that level goes high, the block turns the receive chain on one stage at a time: the supply regulators first, then the crystal oscillator, then the synthesizer. An optional VCO calibration follows. Next come the synthesizer settling wait, then the front end (LNA, mixer and ADC), then the ADC RC calibration. Last of all it enables the digital modem's receive mode.

Two of the waits are fixed-length. The oscillator wait and the synthesizer settling wait each run for a programmed number of cycles on one shared down-counter. The two calibrations run as handshakes: the block gives a one-cycle start pulse and then holds until the matching done input arrives. A 3-bit phase code is exported so that software can read how far the bring-up has gone. Dropping the receive-enable level at any point returns the block to rest, and every enable falls in the same cycle.

States and transitions: ST_IDLE moves to ST_LDO_ON when the enable is high. ST_LDO_ON moves to ST_XO_SETTLE after one cycle. ST_XO_SETTLE moves to ST_PLL_ON when the counter expires. ST_PLL_ON moves to ST_VCO_KICK, or to ST_PLL_SETTLE when VCO calibration is switched off. ST_VCO_KICK moves to ST_VCO_WAIT. ST_VCO_WAIT moves to ST_PLL_SETTLE on done. ST_PLL_SETTLE moves to ST_FE_ON when the counter expires. ST_FE_ON moves to ST_ADC_KICK, which moves to ST_ADC_WAIT. ST_ADC_WAIT moves to ST_RX_ACTIVE on done. From every state except ST_IDLE, a low enable leads back to ST_IDLE.

Top module: `rx_powerup_seq`

## Requirements
- R1: After reset, op_state is 0, and every enable and both start pulses are low.
- R2: In the rest phase (op_state 0), rx_en high moves the block to op_state 1 at the next clock with both regulator enables on. rx_en low keeps it at op_state 0.
- R3: After one cycle at op_state 1, the block holds op_state 2 with xo_en on for exactly xo_settle_cycles+1 cycles, then enters op_state 3 with pll_en on.
- R4: When vco_cal_en is 1 during the first cycle of op_state 3, vco_cal_start pulses high for one cycle in the next cycle. The block then stays at op_state 3 until vco_cal_done is high in a cycle after the pulse. A done in the pulse cycle is ignored.
- R5: When vco_cal_en is 0 during the first cycle of op_state 3, the block goes directly to op_state 4 at the next clock and vco_cal_start stays low.
- R6: The block holds op_state 4 for exactly pll_settle_cycles+1 cycles, then enters op_state 5 with lna_en, mixer_en and adc_en on.
- R7: One cycle after op_state 5 begins, adc_cal_start pulses high for one cycle. After adc_cal_done is high in a later cycle, the block enters op_state 6 with modem_rx_en on, and it stays there while rx_en is high.
- R8: rx_en low in any phase other than 0 returns op_state to 0 at the next clock, with every enable low in that same cycle. This abort takes priority over a done input or a counter expiry in the same cycle.
- R9: Enables follow the phase cumulatively: both regulators at op_state ≥1, xo_en at ≥2, pll_en at ≥3, lna/mixer/adc at ≥5, modem_rx_en at 6. The two start pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Software receive-enable level |
| vco_cal_en | input | 1 | Run the VCO calibration step when 1 |
| xo_settle_cycles | input | CNT_W | Oscillator wait length minus one |
| pll_settle_cycles | input | CNT_W | Synthesizer settling length minus one |
| vco_cal_done | input | 1 | VCO calibration finished |
| adc_cal_done | input | 1 | ADC RC calibration finished |
| ldo_dig_en | output | 1 | Main digital regulator enable |
| ldo_ana_en | output | 1 | Analog regulator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| lna_en | output | 1 | Low-noise amplifier enable |
| mixer_en | output | 1 | Mixer enable |
| adc_en | output | 1 | ADC enable |
| vco_cal_start | output | 1 | One-cycle VCO calibration start |
| adc_cal_start | output | 1 | One-cycle ADC calibration start |
| modem_rx_en | output | 1 | Digital modem receive enable |
| op_state | output | 3 | Phase code 0..6 |

## Verification
An abort can arrive in the same cycle as a step's completion: rx_en falls just as a calibration done rises, or just as the settle counter reaches zero. The bench provokes both collisions. It drops rx_en in the cycle where vco_cal_done is high during the wait, and again in the final cycle of the oscillator wait. In each case it expects op_state 0 with every enable low after the next clock, not the next phase. A done raised in the start-pulse cycle is also checked, to confirm that it leaves the block waiting.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LDO_ON,
        ST_XO_SETTLE,
        ST_PLL_ON,
        ST_VCO_KICK,
        ST_VCO_WAIT,
        ST_PLL_SETTLE,
        ST_FE_ON,
        ST_ADC_KICK,
        ST_ADC_WAIT,
        ST_RX_ACTIVE
    } seq_state_e;

    localparam logic [2:0] PH_IDLE   = 3'd0;
    localparam logic [2:0] PH_SUPPLY = 3'd1;
    localparam logic [2:0] PH_XO     = 3'd2;
    localparam logic [2:0] PH_SYNTH  = 3'd3;
    localparam logic [2:0] PH_SETTLE = 3'd4;
    localparam logic [2:0] PH_FRONT  = 3'd5;
    localparam logic [2:0] PH_RX     = 3'd6;

    // enable vector slots
    localparam int EN_COUNT   = 8;
    localparam int EN_LDO_DIG = 0;
    localparam int EN_LDO_ANA = 1;
    localparam int EN_XO      = 2;
    localparam int EN_PLL     = 3;
    localparam int EN_LNA     = 4;
    localparam int EN_MIX     = 5;
    localparam int EN_ADC     = 6;
    localparam int EN_MODEM   = 7;

    // lowest phase at which an enable slot is on
    function automatic logic [2:0] en_level(input int idx);
        case (idx)
            EN_LDO_DIG, EN_LDO_ANA: return PH_SUPPLY;
            EN_XO:                  return PH_XO;
            EN_PLL:                 return PH_SYNTH;
            EN_LNA, EN_MIX, EN_ADC: return PH_FRONT;
            default:                return PH_RX;
        endcase
    endfunction

endpackage

// File: rtl/rxseq_timer.sv
module rxseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= ZERO;
        else if (load)
            count_q <= load_val;
        else if (count_q != ZERO)
            count_q <= count_q - ONE;
    end

    assign expired = (count_q == ZERO);

endmodule

// File: rtl/rxseq_fsm.sv
module rxseq_fsm
    import rxseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       vco_cal_en,
    input  logic       vco_done,
    input  logic       adc_done,
    input  logic       tmr_expired,
    output logic       tmr_load,
    output logic       tmr_sel_pll,
    output logic       vco_kick,
    output logic       adc_kick,
    output logic [2:0] phase
);
    seq_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (st_q != ST_IDLE && !rx_en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:       if (rx_en) st_d = ST_LDO_ON;
                ST_LDO_ON:     st_d = ST_XO_SETTLE;
                ST_XO_SETTLE:  if (tmr_expired) st_d = ST_PLL_ON;
                ST_PLL_ON:     st_d = vco_cal_en ? ST_VCO_KICK : ST_PLL_SETTLE;
                ST_VCO_KICK:   st_d = ST_VCO_WAIT;
                ST_VCO_WAIT:   if (vco_done) st_d = ST_PLL_SETTLE;
                ST_PLL_SETTLE: if (tmr_expired) st_d = ST_FE_ON;
                ST_FE_ON:      st_d = ST_ADC_KICK;
                ST_ADC_KICK:   st_d = ST_ADC_WAIT;
                ST_ADC_WAIT:   if (adc_done) st_d = ST_RX_ACTIVE;
                ST_RX_ACTIVE:  st_d = ST_RX_ACTIVE;
                default:       st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tmr_load    = 1'b0;
        tmr_sel_pll = 1'b1;
        vco_kick    = 1'b0;
        adc_kick    = 1'b0;
        phase       = PH_IDLE;
        unique case (st_q)
            ST_IDLE: phase = PH_IDLE;
            ST_LDO_ON: begin
                phase       = PH_SUPPLY;
                tmr_load    = rx_en;
                tmr_sel_pll = 1'b0;
            end
            ST_XO_SETTLE: phase = PH_XO;
            ST_PLL_ON: begin
                phase    = PH_SYNTH;
                tmr_load = rx_en && !vco_cal_en;
            end
            ST_VCO_KICK: begin
                phase    = PH_SYNTH;
                vco_kick = 1'b1;
            end
            ST_VCO_WAIT: begin
                phase    = PH_SYNTH;
                tmr_load = rx_en && vco_done;
            end
            ST_PLL_SETTLE: phase = PH_SETTLE;
            ST_FE_ON:      phase = PH_FRONT;
            ST_ADC_KICK: begin
                phase    = PH_FRONT;
                adc_kick = 1'b1;
            end
            ST_ADC_WAIT:  phase = PH_FRONT;
            ST_RX_ACTIVE: phase = PH_RX;
            default:      phase = PH_IDLE;
        endcase
    end

endmodule

// File: rtl/rxseq_enable_bank.sv
module rxseq_enable_bank
    import rxseq_pkg::*;
#(
    parameter int N = EN_COUNT
) (
    input  logic [2:0]   phase,
    output logic [N-1:0] en
);
    for (genvar i = 0; i < N; i++) begin : g_en
        localparam logic [2:0] LVL = en_level(i);
        assign en[i] = (phase >= LVL);
    end
endmodule

// File: rtl/rx_powerup_seq.sv
module rx_powerup_seq
    import rxseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             vco_cal_en,
    input  logic [CNT_W-1:0] xo_settle_cycles,
    input  logic [CNT_W-1:0] pll_settle_cycles,
    input  logic             vco_cal_done,
    input  logic             adc_cal_done,
    output logic             ldo_dig_en,
    output logic             ldo_ana_en,
    output logic             xo_en,
    output logic             pll_en,
    output logic             lna_en,
    output logic             mixer_en,
    output logic             adc_en,
    output logic             vco_cal_start,
    output logic             adc_cal_start,
    output logic             modem_rx_en,
    output logic [2:0]       op_state
);
    logic             tmr_load, tmr_sel_pll, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic [EN_COUNT-1:0] en_vec;

    assign tmr_val = tmr_sel_pll ? pll_settle_cycles : xo_settle_cycles;

    rxseq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    rxseq_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .vco_cal_en  (vco_cal_en),
        .vco_done    (vco_cal_done),
        .adc_done    (adc_cal_done),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_sel_pll (tmr_sel_pll),
        .vco_kick    (vco_cal_start),
        .adc_kick    (adc_cal_start),
        .phase       (op_state)
    );

    rxseq_enable_bank #(.N(EN_COUNT)) i_bank (
        .phase (op_state),
        .en    (en_vec)
    );

    assign ldo_dig_en  = en_vec[EN_LDO_DIG];
    assign ldo_ana_en  = en_vec[EN_LDO_ANA];
    assign xo_en       = en_vec[EN_XO];
    assign pll_en      = en_vec[EN_PLL];
    assign lna_en      = en_vec[EN_LNA];
    assign mixer_en    = en_vec[EN_MIX];
    assign adc_en      = en_vec[EN_ADC];
    assign modem_rx_en = en_vec[EN_MODEM];

endmodule

// File: rtl/rxseq_chk.sv
module rxseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       vco_cal_en,
    input logic       ldo_dig_en,
    input logic       ldo_ana_en,
    input logic       xo_en,
    input logic       pll_en,
    input logic       lna_en,
    input logic       mixer_en,
    input logic       adc_en,
    input logic       vco_cal_start,
    input logic       adc_cal_start,
    input logic       modem_rx_en,
    input logic [2:0] op_state
);
    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == 3'd0 && rx_en) |=> (op_state == 3'd1 && ldo_dig_en && ldo_ana_en));

    assert_vco_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vco_cal_start |=> !vco_cal_start);

    assert_vco_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vco_cal_start |-> $past(vco_cal_en));

    assert_adc_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cal_start |=> !adc_cal_start);

    assert_abort_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && op_state != 3'd0) |=> (op_state == 3'd0 && !ldo_dig_en && !xo_en && !pll_en && !modem_rx_en));

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vco_cal_start, adc_cal_start}));

    assert_modem_needs_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        modem_rx_en |-> (ldo_dig_en && ldo_ana_en && xo_en && pll_en && lna_en && mixer_en && adc_en));

    assert_phase_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state != 3'd0) |-> (op_state >= $past(op_state)));

endmodule

bind rx_powerup_seq rxseq_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .vco_cal_en    (vco_cal_en),
    .ldo_dig_en    (ldo_dig_en),
    .ldo_ana_en    (ldo_ana_en),
    .xo_en         (xo_en),
    .pll_en        (pll_en),
    .lna_en        (lna_en),
    .mixer_en      (mixer_en),
    .adc_en        (adc_en),
    .vco_cal_start (vco_cal_start),
    .adc_cal_start (adc_cal_start),
    .modem_rx_en   (modem_rx_en),
    .op_state      (op_state)
);

// File: tb/test_rx_powerup_seq.sv
`timescale 1ns/1ps
module test_rx_powerup_seq;
    localparam int CNT_W = 16;
    localparam int NVEC  = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, vco_cal_en = 1'b1, vco_cal_done = 1'b0, adc_cal_done = 1'b0;
    logic [CNT_W-1:0] xo_settle_cycles = 16'd2, pll_settle_cycles = 16'd1;
    logic ldo_dig_en, ldo_ana_en, xo_en, pll_en, lna_en, mixer_en, adc_en;
    logic vco_cal_start, adc_cal_start, modem_rx_en;
    logic [2:0] op_state;

    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    rx_powerup_seq #(.CNT_W(CNT_W)) i_rx_powerup_seq (.*);

    // {rx_en, vco_cal_en, vco_done, adc_done, phase, vco_start, adc_start}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'b1100, 3'd1, 2'b00},
        {4'b1100, 3'd2, 2'b00},
        {4'b1100, 3'd2, 2'b00},
        {4'b1100, 3'd2, 2'b00},
        {4'b1100, 3'd3, 2'b00},
        {4'b1100, 3'd3, 2'b10},
        {4'b1100, 3'd3, 2'b00},
        {4'b1100, 3'd3, 2'b00},
        {4'b1110, 3'd4, 2'b00},
        {4'b1100, 3'd4, 2'b00},
        {4'b1100, 3'd5, 2'b00},
        {4'b1100, 3'd5, 2'b01},
        {4'b1100, 3'd5, 2'b00},
        {4'b1101, 3'd6, 2'b00},
        {4'b1100, 3'd6, 2'b00}
    };

    // {modem, adc, mix, lna, pll, xo, ana, dig} expected per phase (R9)
    function automatic logic [7:0] exp_en(input logic [2:0] ph);
        exp_en = {ph == 3'd6, ph >= 3'd5, ph >= 3'd5, ph >= 3'd5,
                  ph >= 3'd3, ph >= 3'd2, ph >= 3'd1, ph >= 3'd1};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_phase(input string req, input logic [2:0] ph, input logic [1:0] kicks);
        check(req, {5'd0, op_state, modem_rx_en, adc_en, mixer_en, lna_en, pll_en, xo_en, ldo_ana_en, ldo_dig_en},
                   {5'd0, ph, exp_en(ph)});
        check(req, {14'd0, vco_cal_start, adc_cal_start}, {14'd0, kicks});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        tick();
        tick();
        check_phase("R1 reset", 3'd0, 2'b00);
        rst_n = 1'b1;
        tick();
        check_phase("R2 stays idle with rx_en low", 3'd0, 2'b00);

        // table walk: full path with VCO calibration, xo=2, pll=1
        for (int i = 0; i < NVEC; i++) begin
            {rx_en, vco_cal_en, vco_cal_done, adc_cal_done} = VEC[i][8:5];
            tick();
            check_phase($sformatf("R3/R4/R6/R7 vector %0d", i), VEC[i][4:2], VEC[i][1:0]);
        end
        vco_cal_done = 1'b0; adc_cal_done = 1'b0;

        // R8 abort from receive
        rx_en = 1'b0;
        tick();
        check_phase("R8 abort from rx active", 3'd0, 2'b00);
        tick();
        check_phase("R2 idle holds", 3'd0, 2'b00);

        // R5 skip path with zero waits
        vco_cal_en = 1'b0; xo_settle_cycles = 16'd0; pll_settle_cycles = 16'd0;
        rx_en = 1'b1;
        tick(); check_phase("R5 supply", 3'd1, 2'b00);
        tick(); check_phase("R3 xo zero wait", 3'd2, 2'b00);
        tick(); check_phase("R3 pll on", 3'd3, 2'b00);
        tick(); check_phase("R5 skip to settle", 3'd4, 2'b00);
        tick(); check_phase("R6 front end", 3'd5, 2'b00);
        tick(); check_phase("R7 adc kick", 3'd5, 2'b01);
        rx_en = 1'b0;
        tick(); check_phase("R8 abort in adc step", 3'd0, 2'b00);

        // R4 done during pulse ignored; R8 abort collides with done
        vco_cal_en = 1'b1; rx_en = 1'b1;
        tick(); tick(); tick();
        check_phase("R4 at pll on", 3'd3, 2'b00);
        vco_cal_done = 1'b1;
        tick(); check_phase("R4 kick cycle", 3'd3, 2'b10);
        tick(); check_phase("R4 early done ignored", 3'd3, 2'b00);
        vco_cal_done = 1'b0;
        tick(); check_phase("R4 still waiting", 3'd3, 2'b00);
        vco_cal_done = 1'b1; rx_en = 1'b0;
        tick(); check_phase("R8 abort beats vco done", 3'd0, 2'b00);
        vco_cal_done = 1'b0;

        // R8 abort beats timer expiry
        rx_en = 1'b1;
        tick(); tick();
        check_phase("R3 xo final cycle", 3'd2, 2'b00);
        rx_en = 1'b0;
        tick(); check_phase("R8 abort beats expiry", 3'd0, 2'b00);

        // R3 oscillator duration with xo=5
        begin
            int cnt = 0;
            xo_settle_cycles = 16'd5; rx_en = 1'b1;
            tick();
            tick();
            while (op_state == 3'd2 && cnt < 100) begin
                cnt++;
                tick();
            end
            check("R3 xo wait length", 16'(cnt), 16'd6);
            check_phase("R3 after xo wait", 3'd3, 2'b00);
        end

        // R1 reset mid-sequence
        rst_n = 1'b0;
        #1;
        check_phase("R1 async reset mid-run", 3'd0, 2'b00);
        rx_en = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        check_phase("R1 after reset release", 3'd0, 2'b00);

        report();
    end
endmodule